// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller quiesces one bus master port before the surrounding subsystem loses power. A single-cycle start pulse raises a halt request toward the fabric. The acknowledge input is then polled at a coarse, fixed interval, measured in microsecond ticks. Polling stops at the first poll that finds the acknowledge high, or after a bounded number of polls with no acknowledge.

The outcome is reported on two sticky flags. One flag means the acknowledge never came within the allowed time. The other means the acknowledge came but the port did not report idle. In both cases, and on success, the request is withdrawn. The port is expected to stay halted until its own reset, which is handled outside this block. A one-cycle done pulse follows the withdrawal.

The poll interval and the total timeout, both in microseconds, are parameters. The timeout must be a whole multiple of the interval, so the number of polls is `TIMEOUT_US / POLL_US`. Defaults are a 50 µs interval and a 100,000 µs timeout.

Top module: `bus_halt_ctrl`

## Requirements
- R1: A start pulse accepted while the controller is free raises `halt_req_o` on the next clock edge and clears both result flags on that same edge.
- R2: The acknowledge is sampled only on every `POLL_US`-th microsecond tick after the request rises. An acknowledge that is high only between polls has no effect, and the request stays high.
- R3: When a poll finds the acknowledge high, the request drops on that clock edge and `timeout_o` stays low. The request therefore lasts exactly k×`POLL_US` ticks when the acknowledge is first seen at poll k.
- R4: If all `TIMEOUT_US/POLL_US` polls find the acknowledge low, the request drops on the last poll's edge with `timeout_o` high and `halt_fail_o` low.
- R5: At the poll that sees the acknowledge, `port_idle_i` is sampled. `halt_fail_o` is set exactly when idle is low at that poll.
- R6: `done_o` is high for exactly one cycle. That cycle directly follows the first cycle in which the request is low.
- R7: `timeout_o` and `halt_fail_o` are never both high. They keep their values after done until the next accepted start.
- R8: A start pulse while a halt is in progress is ignored. The poll schedule and outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a halt sequence (single-cycle pulse) |
| us_tick_i | input | 1 | One-cycle strobe once per microsecond |
| halt_ack_i | input | 1 | Halt acknowledge from the port |
| port_idle_i | input | 1 | Port reports no outstanding transactions |
| halt_req_o | output | 1 | Halt request to the port |
| done_o | output | 1 | One-cycle pulse marking the end of a sequence |
| timeout_o | output | 1 | Sticky: no acknowledge within the timeout |
| halt_fail_o | output | 1 | Sticky: acknowledged but not idle |

## Verification
A wrong interval count or a wrong poll count shows up at the ports as a request that lasts the wrong number of ticks. It is caught on the very edge where the request drops, because the bench counts ticks independently while the request is high. A wrong choice between outcomes appears as a mismatched flag at that same edge. A misplaced done pulse or a flag that drifts is seen within the two to five cycles after the drop, when the bench samples done and the flags again.

// File: rtl/halt_pkg.sv
package halt_pkg;
   typedef enum logic [1:0] {
      HS_IDLE    = 2'd0,
      HS_WAIT    = 2'd1,
      HS_RELEASE = 2'd2
   } halt_state_t;
endpackage

// File: rtl/halt_interval_timer.sv
module halt_interval_timer #(
   parameter int unsigned POLL_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic tick_i,
   output logic poll_o
);
   generate
      if (POLL_US < 1) begin : g_bad
         $error("POLL_US must be at least 1");
      end
      if (POLL_US == 1) begin : g_every
         assign poll_o = run_i && tick_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(POLL_US);
         localparam logic [CW-1:0] LAST = CW'(POLL_US - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (clr_i)            cnt_q <= '0;
            else if (run_i && tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign poll_o = run_i && tick_i && (cnt_q == LAST);

         p_interval_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
         p_interval_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_i && !clr_i) |=> $stable(cnt_q));
      end
   endgenerate
endmodule

// File: rtl/halt_poll_counter.sv
module halt_poll_counter #(
   parameter int unsigned NPOLL = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic poll_i,
   output logic last_o
);
   generate
      if (NPOLL < 1) begin : g_bad
         $error("NPOLL must be at least 1");
      end
      if (NPOLL == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(NPOLL);
         localparam logic [CW-1:0] LAST = CW'(NPOLL - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              cnt_q <= '0;
            else if (clr_i)                          cnt_q <= '0;
            else if (poll_i && (cnt_q != LAST))      cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == LAST);

         p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
         p_poll_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!poll_i && !clr_i) |=> $stable(cnt_q));
      end
   endgenerate
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
   import halt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic poll_i,
   input  logic last_i,
   input  logic ack_i,
   input  logic idle_i,
   output logic accept_o,
   output logic waiting_o,
   output logic req_o,
   output logic done_o,
   output logic timeout_o,
   output logic fail_o
);
   halt_state_t state_q;

   assign accept_o  = start_i && (state_q == HS_IDLE);
   assign waiting_o = (state_q == HS_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= HS_IDLE;
         req_o     <= 1'b0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
         fail_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            HS_IDLE: if (start_i) begin
               state_q   <= HS_WAIT;
               req_o     <= 1'b1;
               timeout_o <= 1'b0;
               fail_o    <= 1'b0;
            end
            HS_WAIT: if (poll_i) begin
               if (ack_i) begin
                  req_o   <= 1'b0;
                  fail_o  <= !idle_i;
                  state_q <= HS_RELEASE;
               end else if (last_i) begin
                  req_o     <= 1'b0;
                  timeout_o <= 1'b1;
                  state_q   <= HS_RELEASE;
               end
            end
            HS_RELEASE: begin
               done_o  <= 1'b1;
               state_q <= HS_IDLE;
            end
            default: state_q <= HS_IDLE;
         endcase
      end
   end

   p_req_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> (req_o && !timeout_o && !fail_o));
   p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_o && !poll_i) |=> req_o);
   p_ack_no_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_o && poll_i && ack_i) |=> (!req_o && !timeout_o));
   p_timeout_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(last_i && poll_i && !ack_i));
   p_fail_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting_o && poll_i && ack_i) |=> (fail_o == !$past(idle_i)));
   p_done_after_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |=> done_o);
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(timeout_o && fail_o));
   p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept_o && !waiting_o) |=> ($stable(timeout_o) && $stable(fail_o)));
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && waiting_o && !poll_i) |=> req_o);
endmodule

// File: rtl/bus_halt_ctrl.sv
module bus_halt_ctrl #(
   parameter int unsigned POLL_US    = 50,
   parameter int unsigned TIMEOUT_US = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic us_tick_i,
   input  logic halt_ack_i,
   input  logic port_idle_i,
   output logic halt_req_o,
   output logic done_o,
   output logic timeout_o,
   output logic halt_fail_o
);
   localparam int unsigned NPOLL = TIMEOUT_US / POLL_US;

   generate
      if (POLL_US == 0 || TIMEOUT_US % POLL_US != 0 || NPOLL == 0) begin : g_chk
         $error("TIMEOUT_US must be a non-zero multiple of POLL_US");
      end
   endgenerate

   logic accept, waiting, poll_stb, poll_last;

   halt_interval_timer #(.POLL_US(POLL_US)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .run_i  (waiting),
      .tick_i (us_tick_i),
      .poll_o (poll_stb)
   );

   halt_poll_counter #(.NPOLL(NPOLL)) u_polls (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (accept),
      .poll_i (poll_stb),
      .last_o (poll_last)
   );

   halt_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .poll_i    (poll_stb),
      .last_i    (poll_last),
      .ack_i     (halt_ack_i),
      .idle_i    (port_idle_i),
      .accept_o  (accept),
      .waiting_o (waiting),
      .req_o     (halt_req_o),
      .done_o    (done_o),
      .timeout_o (timeout_o),
      .fail_o    (halt_fail_o)
   );
endmodule

// File: tb/bus_halt_ctrl_test.sv
module bus_halt_ctrl_test;
   localparam int P   = 4;
   localparam int TO  = 20;
   localparam int NP  = TO / P;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, tick = 1'b0, ack = 1'b0, idle = 1'b1;
   logic req, done, tmo, fail;

   always #2 clk = ~clk;

   bus_halt_ctrl #(.POLL_US(P), .TIMEOUT_US(TO)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .us_tick_i(tick),
      .halt_ack_i(ack), .port_idle_i(idle), .halt_req_o(req),
      .done_o(done), .timeout_o(tmo), .halt_fail_o(fail)
   );

   typedef struct { int ticks; logic tmo; logic fail; } exp_t;
   exp_t q[$];
   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req_tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req_tag, act, expv, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
         $finish;
      end
   endtask

   // Monitor: counts ticks while the request is high and compares against the queue.
   logic req_prev = 1'b0;
   int   tickcnt = 0;
   int   phase = 0;
   exp_t cur;
   always @(negedge clk) if (rst_n) begin
      if (req && !req_prev) begin
         chk(tmo == 0 && fail == 0, "R1 flags cleared", {tmo, fail}, 0);
         tickcnt = 0;
      end
      if (!req && req_prev) begin
         if (q.size() == 0) chk(0, "R3 unexpected drop", 1, 0);
         else begin
            cur = q.pop_front();
            chk(tickcnt == cur.ticks, "R2/R3/R4 request length", tickcnt, cur.ticks);
            chk(tmo == cur.tmo, "R4 timeout flag", tmo, cur.tmo);
            chk(fail == cur.fail, "R5 fail flag", fail, cur.fail);
            chk(done == 0, "R6 done early", done, 0);
            phase = 1;
         end
      end else if (phase == 1) begin
         chk(done == 1, "R6 done pulse", done, 1);
         phase = 2;
      end else if (phase == 2) begin
         chk(done == 0, "R6 done width", done, 0);
         chk({tmo, fail} == {cur.tmo, cur.fail}, "R7 flags held", {tmo, fail}, {cur.tmo, cur.fail});
         phase = 0;
      end else if (done) begin
         chk(0, "R6 stray done", 1, 0);
      end
      if (req && tick) tickcnt++;
      req_prev = req;
   end

   // Driver: ack_poll = first poll index with ack high; glitch drives ack between polls.
   task automatic run_halt(input int ack_poll, input logic idle_v, input bit glitch, input bit restart);
      exp_t e;
      int tickn = 0;
      if (ack_poll <= NP) begin e.ticks = ack_poll * P; e.tmo = 0; e.fail = !idle_v; end
      else begin e.ticks = NP * P; e.tmo = 1; e.fail = 0; end
      q.push_back(e);
      idle = idle_v;
      @(posedge clk); #1 start = 1;
      @(posedge clk); #1 start = 0;
      for (int it = 0; it < 400; it++) begin
         tickn++;
         tick = 1;
         if (tickn % P == 0) ack = (tickn / P >= ack_poll);
         else                ack = glitch;
         start = restart && (tickn == 2);
         @(posedge clk); #1 tick = 0; ack = 0; start = 0;
         @(posedge clk); #1;
         if (!req) break;
      end
      repeat (5) @(posedge clk);
      #1 chk({tmo, fail} == {e.tmo, e.fail}, "R7 flags persist", {tmo, fail}, {e.tmo, e.fail});
      chk(!(tmo && fail), "R7 exclusive", {tmo, fail}, 0);
   endtask

   initial begin
      #(4 * 200000);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk({req, done, tmo, fail} == 4'b0, "R1 reset state", {req, done, tmo, fail}, 0);
      rst_n = 1;
      repeat (2) @(posedge clk);
      #1;
      start = 1;
      @(posedge clk); #1 start = 0;
      chk(req == 1, "R1 request rises next edge", req, 1);
      // finish that sequence with an ack at poll 1
      begin
         exp_t e; e.ticks = P; e.tmo = 0; e.fail = 0; q.push_back(e);
         for (int i = 0; i < P; i++) begin
            tick = 1; ack = (i == P - 1);
            @(posedge clk); #1 tick = 0; ack = 0;
            @(posedge clk); #1;
         end
         repeat (5) @(posedge clk);
      end
      run_halt(1, 1'b0, 0, 0);   // R5 acked, not idle
      run_halt(3, 1'b1, 0, 0);   // R3 ack at third poll
      run_halt(99, 1'b1, 0, 0);  // R4 timeout
      run_halt(NP, 1'b1, 0, 0);  // R3/R4 ack on the final poll is success
      run_halt(99, 1'b0, 1, 0);  // R2 ack only between polls, R4 timeout
      run_halt(2, 1'b1, 1, 1);   // R8 start while busy, R2 glitches
      run_halt(2, 1'b0, 0, 0);   // R1 flags cleared after a timeout-free run
      chk(q.size() == 0, "R3 all sequences completed", q.size(), 0);
      finish_run();
   end
endmodule